// File: doc/BRIEF.md
# Memory Dependence Wakeup Scheduler

This block holds the in-flight loads and stores of an out-of-order core and decides when each one may go to the memory pipeline. When an instruction is inserted, the block asks an external dependence predictor which older store it is likely to read from. It then holds the instruction back until that store has issued and the instruction's register operands are ready. Wakeup follows the predicted producer's sequence number. No addresses are compared.

All live instructions sit in one entry table, searched in parallel by sequence number. Each entry carries a register-ready flag and a memory-ready flag, and it joins the ready set once both are set. Stores also sit in a separate store table, and only a store held there can hold back a dependent. The issue port always offers the oldest ready entry. A squash flushes everything younger than a given sequence number. Notices of store inserts, issues and ordering violations go back to the predictor one cycle later.

The predictor lookup is combinational. The block drives the lookup PC in the insert cycle, and the predicted store sequence number must come back in that same cycle.

Top module: `memdep_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, nothing is offered for issue, insert is accepted (ins_ready high), and no predictor notice is valid.
- R2: An inserted instruction has no memory dependence in any of these cases: the predicted sequence number is 0 (a reserved "none" value), the predicted store is not in the store table, or the predicted store is being issued in that same cycle. Such an instruction becomes offerable in the next cycle if its registers are ready.
- R3: An entry joins the ready set only when its registers are ready and its memory dependence is resolved. The two may be set in either order; a register-ready event (rr_valid with the entry's sequence number) sets the first.
- R4: Every accepted store insert adds the store to the store table. One cycle later pd_store_valid pulses with the store's PC and sequence number.
- R5: When a store issues, every entry waiting on that store gets its memory dependence resolved. Entries whose registers are already ready become offerable in the next cycle. The store leaves the store table.
- R6: Whenever the ready set is not empty, iss_valid is high and iss_seq/iss_pc/iss_is_store describe the ready entry with the smallest sequence number.
- R7: iss_take while iss_valid is high removes the offered entry. In the next cycle pd_issue_valid pulses with its PC, its sequence number and a store flag.
- R8: squash_valid with sequence number N removes every entry and every store-table entry whose sequence number is greater than N. In a squash cycle the insert, take, register-ready and non-speculative-ready inputs are ignored.
- R9: An entry inserted with ins_nonspec set has no store dependence and no predictor lookup. It becomes offerable only after go_valid names its sequence number, whatever its register flag says.
- R10: viol_valid makes pd_train_valid pulse one cycle later, carrying the load PC and the store PC.
- R11: ins_ready is low while the entry table or the store table is full. An insert presented while ins_ready is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert request |
| ins_seq | input | SEQ_W | Sequence number of the inserted instruction (nonzero) |
| ins_pc | input | PC_W | PC of the inserted instruction |
| ins_is_store | input | 1 | 1 = store, 0 = load |
| ins_regs_rdy | input | 1 | Register operands already ready at insert |
| ins_nonspec | input | 1 | Insert as non-speculative |
| ins_ready | output | 1 | Insert can be accepted |
| pd_lookup_valid | output | 1 | Predictor lookup request (same cycle as insert) |
| pd_lookup_pc | output | PC_W | PC to look up |
| pd_lookup_seq | input | SEQ_W | Predicted producing store, 0 = none |
| rr_valid | input | 1 | Registers became ready for an entry |
| rr_seq | input | SEQ_W | Sequence number for rr_valid |
| go_valid | input | 1 | Non-speculative entry may proceed |
| go_seq | input | SEQ_W | Sequence number for go_valid |
| iss_valid | output | 1 | An entry is offered for issue |
| iss_seq | output | SEQ_W | Offered entry sequence number |
| iss_pc | output | PC_W | Offered entry PC |
| iss_is_store | output | 1 | Offered entry is a store |
| iss_take | input | 1 | Consumer takes the offered entry |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Keep entries with sequence number up to this value |
| viol_valid | input | 1 | Ordering violation report |
| viol_load_pc | input | PC_W | PC of the violating load |
| viol_store_pc | input | PC_W | PC of the store it bypassed |
| pd_store_valid | output | 1 | Store insert notice |
| pd_store_pc | output | PC_W | Store PC |
| pd_store_seq | output | SEQ_W | Store sequence number |
| pd_issue_valid | output | 1 | Issue notice |
| pd_issue_pc | output | PC_W | Issued PC |
| pd_issue_seq | output | SEQ_W | Issued sequence number |
| pd_issue_is_store | output | 1 | Issued entry was a store |
| pd_train_valid | output | 1 | Training notice |
| pd_train_load_pc | output | PC_W | Violating load PC |
| pd_train_store_pc | output | PC_W | Related store PC |

## Verification
The assertions take for granted that live sequence numbers are unique and nonzero. They also take for granted that a register-ready or go event names an entry that already exists, and that the stimulus never inserts a store whose number the store table already holds. The random stimulus respects all of this. New sequence numbers only grow, and after a squash to N numbering restarts at N+1. Register-ready events pick waiting entries that are not non-speculative and still have their register flag clear, and go events pick non-speculative entries that are not yet ready. Predicted stores are drawn from stores the bench has inserted, including ones already issued or squashed, plus 0 and numbers that were never used.

// File: rtl/memdep_pkg.sv
package memdep_pkg;

  localparam int DEF_SEQ_W  = 16;
  localparam int DEF_PC_W   = 32;
  localparam int DEF_DEPTH  = 16;
  localparam int DEF_SDEPTH = 8;

  // Per-entry state flags of the entry table
  typedef struct packed {
    logic v;    // entry live
    logic st;   // entry is a store
    logic ns;   // non-speculative, waits for go
    logic rr;   // register operands ready
    logic mr;   // memory dependence resolved
    logic rdy;  // member of the ready set
  } ent_flags_t;

endpackage

// File: rtl/md_store_table.sv
module md_store_table #(
  parameter int SEQ_W  = 16,
  parameter int SDEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEQ_W-1:0] lk_seq,
  output logic             lk_hit,
  input  logic             alloc,
  input  logic [SEQ_W-1:0] alloc_seq,
  input  logic             rm,
  input  logic [SEQ_W-1:0] rm_seq,
  input  logic             sq,
  input  logic [SEQ_W-1:0] sq_seq,
  output logic             full
);
  localparam int SIDX_W = (SDEPTH > 1) ? $clog2(SDEPTH) : 1;

  logic [SDEPTH-1:0] sv;
  logic [SEQ_W-1:0]  sseq [SDEPTH];
  logic [SIDX_W-1:0] free_idx;
  logic [SDEPTH-1:0] lk_match, dup_match;

  always_comb begin
    free_idx = '0;
    for (int k = SDEPTH - 1; k >= 0; k--)
      if (!sv[k]) free_idx = SIDX_W'(k);
  end

  for (genvar j = 0; j < SDEPTH; j++) begin : g_cmp
    assign lk_match[j]  = sv[j] && (sseq[j] == lk_seq);
    assign dup_match[j] = sv[j] && (sseq[j] == alloc_seq);

    always_ff @(posedge clk) begin
      if (rst) begin
        sv[j]   <= 1'b0;
        sseq[j] <= '0;
      end else if (sq) begin
        if (sv[j] && sseq[j] > sq_seq) sv[j] <= 1'b0;
      end else begin
        if (rm && sv[j] && sseq[j] == rm_seq) sv[j] <= 1'b0;
        if (alloc && free_idx == SIDX_W'(j)) begin
          sv[j]   <= 1'b1;
          sseq[j] <= alloc_seq;
        end
      end
    end
  end

  assign lk_hit = |lk_match;
  assign full   = &sv;

  AST_ST_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    (alloc && !sq) |-> !(|dup_match)) else $error("store table duplicate"); // R4

  AST_ST_SQUASHED: assert property (@(posedge clk) disable iff (rst)
    sq |=> !(|(sv & ~$past(sv)))) else $error("store added in squash cycle"); // R8

endmodule

// File: rtl/md_oldest_pick.sv
module md_oldest_pick #(
  parameter int SEQ_W = 16,
  parameter int DEPTH = 16
) (
  input  logic [DEPTH-1:0]             rdy,
  input  logic [SEQ_W-1:0]             seqs [DEPTH],
  output logic                         valid,
  output logic [$clog2(DEPTH)-1:0]     idx
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [SEQ_W-1:0] best;

  always_comb begin
    valid = 1'b0;
    idx   = '0;
    best  = '1;
    for (int k = 0; k < DEPTH; k++) begin
      if (rdy[k] && (!valid || seqs[k] < best)) begin
        valid = 1'b1;
        idx   = IDX_W'(k);
        best  = seqs[k];
      end
    end
  end

endmodule

// File: rtl/memdep_sched.sv
module memdep_sched
  import memdep_pkg::*;
#(
  parameter int SEQ_W  = DEF_SEQ_W,
  parameter int PC_W   = DEF_PC_W,
  parameter int DEPTH  = DEF_DEPTH,
  parameter int SDEPTH = DEF_SDEPTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_valid,
  input  logic [SEQ_W-1:0] ins_seq,
  input  logic [PC_W-1:0]  ins_pc,
  input  logic             ins_is_store,
  input  logic             ins_regs_rdy,
  input  logic             ins_nonspec,
  output logic             ins_ready,
  output logic             pd_lookup_valid,
  output logic [PC_W-1:0]  pd_lookup_pc,
  input  logic [SEQ_W-1:0] pd_lookup_seq,
  input  logic             rr_valid,
  input  logic [SEQ_W-1:0] rr_seq,
  input  logic             go_valid,
  input  logic [SEQ_W-1:0] go_seq,
  output logic             iss_valid,
  output logic [SEQ_W-1:0] iss_seq,
  output logic [PC_W-1:0]  iss_pc,
  output logic             iss_is_store,
  input  logic             iss_take,
  input  logic             squash_valid,
  input  logic [SEQ_W-1:0] squash_seq,
  input  logic             viol_valid,
  input  logic [PC_W-1:0]  viol_load_pc,
  input  logic [PC_W-1:0]  viol_store_pc,
  output logic             pd_store_valid,
  output logic [PC_W-1:0]  pd_store_pc,
  output logic [SEQ_W-1:0] pd_store_seq,
  output logic             pd_issue_valid,
  output logic [PC_W-1:0]  pd_issue_pc,
  output logic [SEQ_W-1:0] pd_issue_seq,
  output logic             pd_issue_is_store,
  output logic             pd_train_valid,
  output logic [PC_W-1:0]  pd_train_load_pc,
  output logic [PC_W-1:0]  pd_train_store_pc
);
  localparam int IDX_W = $clog2(DEPTH);

  ent_flags_t        fl   [DEPTH];
  logic [SEQ_W-1:0]  eseq [DEPTH];
  logic [PC_W-1:0]   pc_mem [DEPTH];
  logic [DEPTH-1:0]  vvec, rdyvec;
  logic [IDX_W-1:0]  free_idx, pick_idx;
  logic              pick_valid;
  logic              st_hit, st_full;
  logic              ins_fire, take_fire, dep_live, store_issuing;

  for (genvar i = 0; i < DEPTH; i++) begin : g_vec
    assign vvec[i]   = fl[i].v;
    assign rdyvec[i] = fl[i].v && fl[i].rdy;
  end

  // lowest free slot of the entry table
  always_comb begin
    free_idx = '0;
    for (int k = DEPTH - 1; k >= 0; k--)
      if (!vvec[k]) free_idx = IDX_W'(k);
  end

  assign ins_ready = !(&vvec) && !st_full;
  assign ins_fire  = ins_valid && ins_ready && !squash_valid;

  assign pd_lookup_valid = ins_fire && !ins_nonspec;
  assign pd_lookup_pc    = ins_pc;

  md_oldest_pick #(.SEQ_W(SEQ_W), .DEPTH(DEPTH)) pick_i (
    .rdy   (rdyvec),
    .seqs  (eseq),
    .valid (pick_valid),
    .idx   (pick_idx)
  );

  assign iss_valid     = pick_valid;
  assign iss_seq       = eseq[pick_idx];
  assign iss_pc        = pc_mem[pick_idx];
  assign iss_is_store  = fl[pick_idx].st;
  assign take_fire     = iss_valid && iss_take && !squash_valid;
  assign store_issuing = take_fire && iss_is_store;

  md_store_table #(.SEQ_W(SEQ_W), .SDEPTH(SDEPTH)) stab_i (
    .clk       (clk),
    .rst       (rst),
    .lk_seq    (pd_lookup_seq),
    .lk_hit    (st_hit),
    .alloc     (ins_fire && ins_is_store),
    .alloc_seq (ins_seq),
    .rm        (store_issuing),
    .rm_seq    (iss_seq),
    .sq        (squash_valid),
    .sq_seq    (squash_seq),
    .full      (st_full)
  );

  // a dependence counts only on a tracked store that is not leaving now
  assign dep_live = !ins_nonspec && (|pd_lookup_seq) && st_hit &&
                    !(store_issuing && iss_seq == pd_lookup_seq);

  // PC storage: written once at insert, read at the picked index
  always_ff @(posedge clk) begin
    if (ins_fire) pc_mem[free_idx] <= ins_pc;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    ent_flags_t       f;
    logic [SEQ_W-1:0] s, d;
    logic             wake, rhit, ghit, rr_n, mr_n;

    always_comb begin
      wake = f.v && !f.mr && store_issuing && (d == iss_seq);
      rhit = f.v && rr_valid && (s == rr_seq);
      ghit = f.v && f.ns && go_valid && (s == go_seq);
      rr_n = f.rr || rhit;
      mr_n = f.mr || wake;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        f <= '0;
        s <= '0;
        d <= '0;
      end else if (squash_valid) begin
        if (f.v && s > squash_seq) f <= '0;
      end else if (take_fire && pick_idx == IDX_W'(i)) begin
        f <= '0;
      end else if (ins_fire && free_idx == IDX_W'(i)) begin
        f.v   <= 1'b1;
        f.st  <= ins_is_store;
        f.ns  <= ins_nonspec;
        f.rr  <= ins_regs_rdy;
        f.mr  <= !dep_live;
        f.rdy <= !ins_nonspec && ins_regs_rdy && !dep_live;
        s     <= ins_seq;
        d     <= pd_lookup_seq;
      end else if (f.v) begin
        f.rr  <= rr_n;
        f.mr  <= mr_n;
        f.rdy <= f.rdy || ghit || (!f.ns && rr_n && mr_n);
      end
    end

    assign fl[i]   = f;
    assign eseq[i] = s;
  end

  // registered notices to the predictor
  always_ff @(posedge clk) begin
    if (rst) begin
      pd_store_valid    <= 1'b0;
      pd_store_pc       <= '0;
      pd_store_seq      <= '0;
      pd_issue_valid    <= 1'b0;
      pd_issue_pc       <= '0;
      pd_issue_seq      <= '0;
      pd_issue_is_store <= 1'b0;
      pd_train_valid    <= 1'b0;
      pd_train_load_pc  <= '0;
      pd_train_store_pc <= '0;
    end else begin
      pd_store_valid    <= ins_fire && ins_is_store;
      pd_store_pc       <= ins_pc;
      pd_store_seq      <= ins_seq;
      pd_issue_valid    <= take_fire;
      pd_issue_pc       <= iss_pc;
      pd_issue_seq      <= iss_seq;
      pd_issue_is_store <= iss_is_store;
      pd_train_valid    <= viol_valid;
      pd_train_load_pc  <= viol_load_pc;
      pd_train_store_pc <= viol_store_pc;
    end
  end

  AST_STORE_NOTICE: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && ins_ready && !squash_valid && ins_is_store) |=>
      (pd_store_valid && pd_store_seq == $past(ins_seq))) else $error("store notice"); // R4

  AST_ISSUE_NOTICE: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_take && !squash_valid) |=>
      (pd_issue_valid && pd_issue_seq == $past(iss_seq))) else $error("issue notice"); // R7

  AST_SQUASH_YOUNG: assert property (@(posedge clk) disable iff (rst)
    squash_valid |=> (!iss_valid || iss_seq <= $past(squash_seq))) else $error("squash left young entry"); // R8

  AST_TRAIN_FWD: assert property (@(posedge clk) disable iff (rst)
    viol_valid |=> (pd_train_valid && pd_train_load_pc == $past(viol_load_pc))) else $error("train notice"); // R10

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && !ins_ready) |=> ($countones(vvec) <= $past($countones(vvec)))) else $error("insert when full"); // R11

  AST_TAKE_LEAVES: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_take && !squash_valid && !(ins_valid && ins_ready)) |=>
      ($countones(vvec) < $past($countones(vvec)))) else $error("taken entry stayed"); // R7

endmodule

// File: tb/memdep_sched_tb_top.sv
module memdep_sched_tb_top;
  localparam int SW = 16, PW = 32, ND = 16, NS = 8;

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic ins_valid = 0, ins_is_store = 0, ins_regs_rdy = 0, ins_nonspec = 0;
  logic [SW-1:0] ins_seq = 0, pd_lookup_seq = 0, rr_seq = 0, go_seq = 0, squash_seq = 0;
  logic [PW-1:0] ins_pc = 0, viol_load_pc = 0, viol_store_pc = 0;
  logic rr_valid = 0, go_valid = 0, iss_take = 0, squash_valid = 0, viol_valid = 0;
  logic ins_ready, pd_lookup_valid, iss_valid, iss_is_store;
  logic [PW-1:0] pd_lookup_pc, iss_pc, pd_store_pc, pd_issue_pc, pd_train_load_pc, pd_train_store_pc;
  logic [SW-1:0] iss_seq, pd_store_seq, pd_issue_seq;
  logic pd_store_valid, pd_issue_valid, pd_issue_is_store, pd_train_valid;

  memdep_sched #(.SEQ_W(SW), .PC_W(PW), .DEPTH(ND), .SDEPTH(NS)) dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  bit m_v[ND], m_st[ND], m_ns[ND], m_rr[ND], m_mr[ND], m_rdy[ND];
  int m_seq[ND], m_dep[ND];
  bit ms_v[NS];
  int ms_seq[NS];
  bit e_ps_v, e_pi_v, e_pi_st, e_tr_v;
  int e_ps_seq, e_pi_seq;
  logic [PW-1:0] e_tr_l, e_tr_s;

  function automatic logic [PW-1:0] pc_of(int s); return {16'hA5C0, 16'(s)}; endfunction
  function automatic int cnt_e(); int c = 0; for (int j = 0; j < ND; j++) c += m_v[j]; return c; endfunction
  function automatic int cnt_s(); int c = 0; for (int j = 0; j < NS; j++) c += ms_v[j]; return c; endfunction
  function automatic bit m_ready(); return cnt_e() < ND && cnt_s() < NS; endfunction
  function automatic int oldest();
    int o = -1;
    for (int j = 0; j < ND; j++)
      if (m_v[j] && m_rdy[j] && (o < 0 || m_seq[j] < m_seq[o])) o = j;
    return o;
  endfunction
  function automatic bit tracked(int s);
    for (int j = 0; j < NS; j++) if (ms_v[j] && ms_seq[j] == s) return 1;
    return 0;
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    int o = oldest();
    bit take = iss_take && o >= 0 && !squash_valid;
    bit fire = ins_valid && m_ready() && !squash_valid;
    e_ps_v = fire && ins_is_store; e_ps_seq = ins_seq;
    e_pi_v = take; e_tr_v = viol_valid; e_tr_l = viol_load_pc; e_tr_s = viol_store_pc;
    if (take) begin e_pi_seq = m_seq[o]; e_pi_st = m_st[o]; end
    if (squash_valid) begin
      for (int j = 0; j < ND; j++) if (m_v[j] && m_seq[j] > squash_seq) m_v[j] = 0;
      for (int j = 0; j < NS; j++) if (ms_v[j] && ms_seq[j] > squash_seq) ms_v[j] = 0;
      return;
    end
    begin
      bit dep = !ins_nonspec && pd_lookup_seq != 0 && tracked(pd_lookup_seq) &&
                !(take && m_st[o] && m_seq[o] == pd_lookup_seq);
      for (int j = 0; j < ND; j++) begin
        if (m_v[j] && !(take && j == o)) begin
          if (take && m_st[o] && !m_mr[j] && m_dep[j] == m_seq[o]) m_mr[j] = 1;
          if (rr_valid && m_seq[j] == rr_seq) m_rr[j] = 1;
          if ((go_valid && m_ns[j] && m_seq[j] == go_seq) || (!m_ns[j] && m_rr[j] && m_mr[j])) m_rdy[j] = 1;
        end
      end
      if (take) begin
        m_v[o] = 0;
        if (m_st[o]) for (int j = 0; j < NS; j++) if (ms_v[j] && ms_seq[j] == m_seq[o]) ms_v[j] = 0;
      end
      if (fire) begin
        for (int j = 0; j < ND; j++) if (!m_v[j]) begin
          m_v[j] = 1; m_seq[j] = ins_seq; m_st[j] = ins_is_store; m_ns[j] = ins_nonspec;
          m_rr[j] = ins_regs_rdy; m_mr[j] = !dep; m_dep[j] = pd_lookup_seq;
          m_rdy[j] = !ins_nonspec && ins_regs_rdy && !dep;
          break;
        end
        if (ins_is_store) for (int j = 0; j < NS; j++) if (!ms_v[j]) begin
          ms_v[j] = 1; ms_seq[j] = ins_seq; break;
        end
      end
    end
  endtask

  task automatic check_out(string tag);
    int o = oldest();
    chk(ins_ready == m_ready(), tag, "ins_ready", ins_ready, m_ready());
    chk(iss_valid == (o >= 0), tag, "iss_valid", iss_valid, o >= 0);
    if (o >= 0 && iss_valid) begin
      chk(iss_seq == m_seq[o], tag, "iss_seq", iss_seq, m_seq[o]);
      chk(iss_pc == pc_of(m_seq[o]), tag, "iss_pc", iss_pc, pc_of(m_seq[o]));
      chk(iss_is_store == m_st[o], tag, "iss_is_store", iss_is_store, m_st[o]);
    end
    chk(pd_store_valid == e_ps_v, tag, "pd_store_valid", pd_store_valid, e_ps_v);
    if (e_ps_v) chk(pd_store_seq == e_ps_seq && pd_store_pc == pc_of(e_ps_seq), tag, "pd_store_seq", pd_store_seq, e_ps_seq);
    chk(pd_issue_valid == e_pi_v, tag, "pd_issue_valid", pd_issue_valid, e_pi_v);
    if (e_pi_v) begin
      chk(pd_issue_seq == e_pi_seq && pd_issue_pc == pc_of(e_pi_seq), tag, "pd_issue_seq", pd_issue_seq, e_pi_seq);
      chk(pd_issue_is_store == e_pi_st, tag, "pd_issue_is_store", pd_issue_is_store, e_pi_st);
    end
    chk(pd_train_valid == e_tr_v, tag, "pd_train_valid", pd_train_valid, e_tr_v);
    if (e_tr_v) chk(pd_train_load_pc == e_tr_l && pd_train_store_pc == e_tr_s, tag, "pd_train_pcs", pd_train_load_pc, e_tr_l);
  endtask

  task automatic idle();
    ins_valid = 0; ins_nonspec = 0; ins_regs_rdy = 0; ins_is_store = 0; pd_lookup_seq = 0;
    rr_valid = 0; go_valid = 0; iss_take = 0; squash_valid = 0; viol_valid = 0;
  endtask

  task automatic cyc(string tag);
    #1;
    chk(pd_lookup_valid == (ins_valid && m_ready() && !squash_valid && !ins_nonspec),
        tag, "pd_lookup_valid", pd_lookup_valid, 0);
    model_step();
    @(posedge clk); @(negedge clk);
    check_out(tag);
    idle();
  endtask

  task automatic ins(int s, bit st, bit rr, bit ns, int pred);
    ins_valid = 1; ins_seq = 16'(s); ins_pc = pc_of(s); ins_is_store = st;
    ins_regs_rdy = rr; ins_nonspec = ns; pd_lookup_seq = 16'(pred);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int nseq;
    void'($urandom(32'h5EED_1234));
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_out("R1");
    rst = 0;
    @(negedge clk);
    check_out("R1");
    // R2: no predicted store
    ins(10, 0, 1, 0, 0); cyc("R2");
    iss_take = 1; cyc("R7");
    // R4/R3/R5: load waits on store, store regs come later
    ins(20, 1, 0, 0, 0); cyc("R4");
    ins(21, 0, 1, 0, 20); cyc("R3");
    rr_valid = 1; rr_seq = 20; cyc("R3");
    iss_take = 1; cyc("R5");
    iss_take = 1; cyc("R7");
    // R3 other order: memory resolved first, registers later
    ins(30, 1, 1, 0, 0); cyc("R4");
    ins(31, 0, 0, 0, 30); cyc("R3");
    iss_take = 1; cyc("R5");
    rr_valid = 1; rr_seq = 31; cyc("R3");
    iss_take = 1; cyc("R3");
    // R2: untracked predicted store, and store issuing in the same cycle
    ins(40, 0, 1, 0, 25); cyc("R2");
    iss_take = 1; cyc("R2");
    ins(41, 1, 1, 0, 0); cyc("R4");
    ins(42, 0, 1, 0, 41); iss_take = 1; cyc("R2");
    iss_take = 1; cyc("R2");
    // R6: oldest first
    ins(50, 0, 0, 0, 0); cyc("R6");
    ins(52, 0, 1, 0, 0); cyc("R6");
    ins(51, 0, 1, 0, 0); cyc("R6");
    rr_valid = 1; rr_seq = 50; cyc("R6");
    repeat (3) begin iss_take = 1; cyc("R6"); end
    // R9: non-speculative waits for go
    ins(60, 0, 1, 1, 0); cyc("R9");
    cyc("R9");
    go_valid = 1; go_seq = 60; cyc("R9");
    iss_take = 1; cyc("R9");
    // R10
    viol_valid = 1; viol_load_pc = 32'h1234_0040; viol_store_pc = 32'h1234_0010; cyc("R10");
    // R11: entry table full, then an older ready insert is ignored
    for (int k = 0; k < ND; k++) begin ins(100 + k, 0, 0, 0, 0); cyc("R11"); end
    ins(70, 0, 1, 0, 0); cyc("R11");
    // R8: squash everything younger than 99, and ignore an insert in that cycle
    squash_valid = 1; squash_seq = 99; ins(80, 0, 1, 0, 0); cyc("R8");
    cyc("R8");
    // R11: store table full
    for (int k = 0; k < NS; k++) begin ins(120 + k, 1, 0, 0, 0); cyc("R11"); end
    ins(90, 0, 1, 0, 0); cyc("R11");
    // R8: squash part of the stores, then a dependent on a removed store is free
    squash_valid = 1; squash_seq = 123; cyc("R8");
    ins(124, 0, 1, 0, 126); cyc("R8");
    squash_valid = 1; squash_seq = 99; cyc("R8");
    // random phase
    nseq = 200;
    for (int c = 0; c < 4000; c++) begin
      int r = $urandom % 100;
      if (r < 4 && nseq > 205) begin
        squash_valid = 1; squash_seq = 16'(nseq - 1 - ($urandom % 6));
        nseq = squash_seq + 1;
      end else begin
        if ($urandom % 100 < 55 && m_ready()) begin
          int p = 0;
          int sel = $urandom % 4;
          if (sel == 1) p = nseq - 1 - ($urandom % 8);
          else if (sel == 2) p = 60000 + ($urandom % 100);
          else if (sel == 3) begin
            for (int j = 0; j < NS; j++) if (ms_v[j] && ($urandom % 2)) p = ms_seq[j];
          end
          ins(nseq, $urandom % 2, $urandom % 2, ($urandom % 10) == 0, p);
          nseq++;
        end
        if (iss_valid && ($urandom % 100 < 45)) iss_take = 1;
        begin
          int j = $urandom % ND;
          if (m_v[j] && !m_ns[j] && !m_rr[j]) begin rr_valid = 1; rr_seq = 16'(m_seq[j]); end
          j = $urandom % ND;
          if (m_v[j] && m_ns[j] && !m_rdy[j]) begin go_valid = 1; go_seq = 16'(m_seq[j]); end
        end
        if ($urandom % 20 == 0) begin
          viol_valid = 1; viol_load_pc = $urandom; viol_store_pc = $urandom;
        end
      end
      cyc("R6");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule